// File: doc/BRIEF.md
# Keyed Register Write-Protection Unit

This block shields the configuration state of a low-power timekeeping peripheral from stray bus writes. A simple register port (address, write data, write strobe, combinational read data) reaches two key registers, a read-only status word, one configuration register and a bank of timing registers. The protected registers only accept writes once each key register holds its own 32-bit magic value. Loading any other value, such as zero, into either key locks the file again.

A second guard follows the slow 32.768 kHz update cycle. The slow clock comes in asynchronously and is synchronised. Each rising edge starts a busy period of a fixed number of bus cycles. When busy ends, a short access window opens. Timing registers accept writes only while the file is unlocked and the window is open. The configuration register needs only the unlock. Software is expected to poll the busy bit, with a bounded retry count, before it touches the keys.

Top module: `kick_guard`

## Requirements
- R1: After reset the block is locked, both keys are cleared, busy and window are low, and the configuration and timing registers read zero.
- R2: The key registers sit at offsets 0x6C (first key, unlock value 0x83E70B13) and 0x70 (second key, unlock value 0x95A4F1E0). Writes to them are always accepted, whether the block is locked or not.
- R3: `unlocked_o` is high only while both keys hold their unlock values at the same time. A wrong value in either key keeps it low. It rises in the cycle after the write that completes the pair.
- R4: Writing zero, or any non-matching value, to either key locks the block again from the next cycle.
- R5: While the block is locked, writes to the configuration register (offset 0x54) and to the timing registers are dropped.
- R6: Busy rises on the third bus clock edge after a rising edge of the slow clock is first sampled. It stays high for BUSY_CYC cycles. It reads as bit 0 of the status word at offset 0x44.
- R7: The access window opens in the cycle after busy falls and stays open for WIN_CYC cycles. It reads as status bit 1. A new slow-clock edge closes the window and restarts busy. Busy and window are never high together.
- R8: Timing register i sits at offset 4*i (N_TIME registers). A write to it takes effect only when the block is unlocked and the window is open. Otherwise it is dropped.
- R9: Both key registers read as zero. Status bit 2 reads as the unlocked state. Status writes have no effect. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_in | input | 1 | Asynchronous 32.768 kHz update clock |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| unlocked_o | output | 1 | Both keys match |
| busy_o | output | 1 | Slow-domain update in progress |
| window_o | output | 1 | Safe access window open |
| cfg_o | output | 32 | Configuration register contents |

## Verification
The key pair is exercised with these orders:
- only the first key correct;
- both keys correct;
- one key overwritten with a wrong value;
- both keys zeroed.

Together these separate "both keys match" from "the last key write matched" and from a sticky unlock.

Protected writes are tried in every combination of lock state and slow-clock phase: outside any window, during busy, inside the window, and after relock. This shows that the configuration register needs only the unlock, while the timing bank also needs the window.

A second slow-clock edge is raised inside an open window. This shows that busy restarts and cuts the window short rather than letting the two overlap.

// File: rtl/kg_pkg.sv
package kg_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h44;
  localparam logic [7:0] OFF_KEY_A  = 8'h6C;
  localparam logic [7:0] OFF_KEY_B  = 8'h70;
  localparam logic [7:0] OFF_CFG    = 8'h54;
  localparam logic [7:0] OFF_TIME0  = 8'h00;

  localparam logic [31:0] MAGIC_A = 32'h83E7_0B13;
  localparam logic [31:0] MAGIC_B = 32'h95A4_F1E0;

  // Both keys must match simultaneously
  function automatic logic keys_open(input logic [31:0] ka, input logic [31:0] kb);
    return (ka == MAGIC_A) && (kb == MAGIC_B);
  endfunction

  // Status layout: bit0 busy, bit1 window, bit2 unlocked
  function automatic logic [31:0] status_word(input logic busy, input logic win,
                                              input logic unl);
    return {29'd0, unl, win, busy};
  endfunction

  function automatic logic [7:0] time_offset(input int idx);
    return OFF_TIME0 + 8'(idx * 4);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/kg_slow_window.sv
module kg_slow_window #(
  parameter int BUSY_CYC = 8,
  parameter int WIN_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_in,
  output logic busy_o,
  output logic win_o
);
  localparam int CW = $clog2(kg_pkg::max2(BUSY_CYC, WIN_CYC) + 1);

  logic [2:0]    sync_q;
  logic          tick;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], slow_in};
  end

  assign tick = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      win_o  <= 1'b0;
      cnt_q  <= '0;
    end else if (tick) begin
      busy_o <= 1'b1;
      win_o  <= 1'b0;
      cnt_q  <= CW'(BUSY_CYC - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) begin
        busy_o <= 1'b0;
        win_o  <= 1'b1;
        cnt_q  <= CW'(WIN_CYC - 1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (win_o) begin
      if (cnt_q == '0) win_o <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_busy_win_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && win_o));
  assert_win_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |-> $past(busy_o));
  assert_busy_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(tick));
endmodule

// File: rtl/kg_key_lock.sv
module kg_key_lock (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_b,
  input  logic [31:0] wdata,
  output logic        unlocked_o
);
  logic [31:0] key_a_q, key_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a_q <= '0;
      key_b_q <= '0;
    end else begin
      if (wr_a) key_a_q <= wdata;
      if (wr_b) key_b_q <= wdata;
    end
  end

  assign unlocked_o = kg_pkg::keys_open(key_a_q, key_b_q);

  assert_unlock_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(wr_a || wr_b));
  assert_relock_by_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked_o) |-> $past(wr_a || wr_b));
endmodule

// File: rtl/kg_prot_regs.sv
module kg_prot_regs #(
  parameter int N_TIME = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   unlocked,
  input  logic                   win,
  input  logic                   cfg_wr,
  input  logic [N_TIME-1:0]      time_wr,
  input  logic [31:0]            wdata,
  output logic [31:0]            cfg_q,
  output logic [N_TIME-1:0][31:0] time_q
);
  logic time_ok;
  assign time_ok = unlocked & win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cfg_q <= '0;
    else if (cfg_wr && unlocked) cfg_q <= wdata;
  end

  for (genvar i = 0; i < N_TIME; i++) begin : g_time
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    time_q[i] <= '0;
      else if (time_wr[i] && time_ok) time_q[i] <= wdata;
    end

    assert_time_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(unlocked && win) |=> $stable(time_q[i]));
  end

  assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(cfg_q));
endmodule

// File: rtl/kick_guard.sv
module kick_guard #(
  parameter int ADDR_W   = 8,
  parameter int N_TIME   = 4,
  parameter int BUSY_CYC = 8,
  parameter int WIN_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              unlocked_o,
  output logic              busy_o,
  output logic              window_o,
  output logic [31:0]       cfg_o
);
  import kg_pkg::*;

  logic                    hit_key_a, hit_key_b, hit_cfg, hit_stat;
  logic [N_TIME-1:0]       hit_time;
  logic [N_TIME-1:0][31:0] time_q;

  assign hit_key_a = (bus_addr == ADDR_W'(OFF_KEY_A));
  assign hit_key_b = (bus_addr == ADDR_W'(OFF_KEY_B));
  assign hit_cfg   = (bus_addr == ADDR_W'(OFF_CFG));
  assign hit_stat  = (bus_addr == ADDR_W'(OFF_STATUS));

  for (genvar i = 0; i < N_TIME; i++) begin : g_dec
    assign hit_time[i] = (bus_addr == ADDR_W'(time_offset(i)));
  end

  kg_slow_window #(.BUSY_CYC(BUSY_CYC), .WIN_CYC(WIN_CYC)) u_slow (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_clk_in),
    .busy_o(busy_o), .win_o(window_o));

  kg_key_lock u_keys (
    .clk(clk), .rst_n(rst_n),
    .wr_a(bus_we & hit_key_a), .wr_b(bus_we & hit_key_b),
    .wdata(bus_wdata), .unlocked_o(unlocked_o));

  kg_prot_regs #(.N_TIME(N_TIME)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .unlocked(unlocked_o), .win(window_o),
    .cfg_wr(bus_we & hit_cfg), .time_wr({N_TIME{bus_we}} & hit_time),
    .wdata(bus_wdata), .cfg_q(cfg_o), .time_q(time_q));

  always_comb begin
    bus_rdata = '0;
    if (hit_stat) bus_rdata = status_word(busy_o, window_o, unlocked_o);
    if (hit_cfg)  bus_rdata = cfg_o;
    for (int i = 0; i < N_TIME; i++)
      if (hit_time[i]) bus_rdata = time_q[i];
  end

  assert_key_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_key_a || hit_key_b) |-> (bus_rdata == 32'd0));
  assert_cfg_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked_o && bus_we && hit_cfg) |=> $stable(cfg_o));
endmodule

// File: tb/kick_guard_tb_top.sv
module kick_guard_tb_top;
  localparam int CLK_P = 10;
  localparam int B = 8;
  localparam int W = 4;
  localparam int NT = 4;

  logic clk = 0, rst_n = 0, slow = 0, we = 0;
  logic [7:0]  addr = 8'hFF;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, cfg;
  logic unl, busy, win;

  int checks = 0, fails = 0, ec = 0;
  int t_prev = -1000, t_last = -1000;
  logic [31:0] m_ka = 0, m_kb = 0, m_cfg = 0;
  logic [31:0] m_time [NT];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  kick_guard #(.ADDR_W(8), .N_TIME(NT), .BUSY_CYC(B), .WIN_CYC(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(slow), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata), .unlocked_o(unl),
    .busy_o(busy), .window_o(win), .cfg_o(cfg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, ec);
    end
  endtask

  function automatic int tsel(input int k);
    return (k >= t_last + 2) ? t_last : t_prev;
  endfunction
  function automatic bit e_busy(input int k);
    int t = tsel(k);
    return (k >= t + 2) && (k <= t + B + 1);
  endfunction
  function automatic bit e_win(input int k);
    int t = tsel(k);
    return (k >= t + B + 2) && (k <= t + B + W + 1);
  endfunction
  function automatic bit e_unl();
    return (m_ka == 32'h83E70B13) && (m_kb == 32'h95A4F1E0);
  endfunction
  function automatic logic [31:0] e_read(input logic [7:0] a);
    if (a == 8'h44) return {29'd0, e_unl(), e_win(ec), e_busy(ec)};
    if (a == 8'h54) return m_cfg;
    for (int i = 0; i < NT; i++) if (a == 8'(4*i)) return m_time[i];
    return 32'd0;
  endfunction

  // Reference model and per-cycle comparison
  always @(posedge clk) begin
    if (rst_n) begin
      bit wok;
      ec++;
      wok = e_unl() && e_win(ec - 1);
      if (we) begin
        if (addr == 8'h54 && e_unl()) m_cfg = wdata;
        for (int i = 0; i < NT; i++) if (addr == 8'(4*i) && wok) m_time[i] = wdata;
        if (addr == 8'h6C) m_ka = wdata;
        if (addr == 8'h70) m_kb = wdata;
      end
      #(CLK_P/4);
      if (!done) begin
        chk("R6 busy", 32'(busy), 32'(e_busy(ec)));
        chk("R7 window", 32'(win), 32'(e_win(ec)));
        chk("R3 unlocked", 32'(unl), 32'(e_unl()));
        chk("R5 cfg", cfg, m_cfg);
        chk("R9 rdata", rdata, e_read(addr));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = 8'hFF;
  endtask
  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask
  task automatic slow_pulse();
    @(negedge clk); slow = 1; t_prev = t_last; t_last = ec + 1;
    repeat (4) @(negedge clk);
    slow = 0;
  endtask
  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NT; i++) m_time[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 unlocked", 32'(unl), 0); chk("R1 busy", 32'(busy), 0);
    chk("R1 window", 32'(win), 0);   chk("R1 cfg", cfg, 0);
    rst_n = 1;
    rd_chk("R1 status", 8'h44, 0);
    // R5: locked cfg write dropped
    wr(8'h54, 32'hDEAD_BEEF);
    rd_chk("R5 cfg locked", 8'h54, 0);
    // R3: only first key right
    wr(8'h6C, 32'h83E70B13);
    wr(8'h70, 32'h95A4F1E1);
    chk("R3 one key wrong", 32'(unl), 0);
    // R2: second key right -> unlock
    wr(8'h70, 32'h95A4F1E0);
    chk("R2 both keys", 32'(unl), 1);
    rd_chk("R9 key A hidden", 8'h6C, 0);
    rd_chk("R9 key B hidden", 8'h70, 0);
    rd_chk("R9 status unlocked", 8'h44, 32'h4);
    wr(8'h44, 32'hFFFF_FFFF);
    rd_chk("R9 status write ignored", 8'h44, 32'h4);
    rd_chk("R9 unmapped", 8'h20, 0);
    wr(8'h54, 32'h1234_5678);
    rd_chk("R5 cfg unlocked", 8'h54, 32'h1234_5678);
    // R8: timing write outside window dropped
    wr(8'h04, 32'hAAAA_0001);
    rd_chk("R8 outside window", 8'h04, 0);
    // R6/R8: write during busy dropped, in window accepted
    slow_pulse();
    while (!busy) @(negedge clk);
    wr(8'h08, 32'hBBBB_0002);
    rd_chk("R8 during busy", 8'h08, 0);
    while (!win) @(negedge clk);
    wr(8'h0C, 32'hCCCC_0003);
    rd_chk("R8 in window", 8'h0C, 32'hCCCC_0003);
    repeat (10) @(negedge clk);
    // R7: new edge inside window restarts busy
    slow_pulse();
    while (!win) @(negedge clk);
    slow_pulse();
    repeat (4) @(negedge clk);
    chk("R7 restart busy", 32'(busy), 1);
    chk("R7 window closed", 32'(win), 0);
    repeat (20) @(negedge clk);
    // R4: wrong key relocks, then zeros keep locked
    wr(8'h70, 32'h0000_0001);
    chk("R4 wrong key relock", 32'(unl), 0);
    wr(8'h70, 32'h95A4F1E0);
    chk("R3 relock undone", 32'(unl), 1);
    wr(8'h6C, 0); wr(8'h70, 0);
    chk("R4 zero keys", 32'(unl), 0);
    wr(8'h54, 32'h0BAD_0BAD);
    rd_chk("R5 cfg after relock", 8'h54, 32'h1234_5678);
    // R5/R8: locked write in window dropped
    slow_pulse();
    while (!win) @(negedge clk);
    wr(8'h00, 32'h5555_5555);
    rd_chk("R8 locked in window", 8'h00, 0);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule